// File: doc/BRIEF.md
# NAND Byte-to-Halfword Host Bridge

This block sits between a 16-bit memory-mapped processor bus and an 8-bit NAND flash device. Software reaches the flash through a data port and three small control registers. One mode register drives the flash control pins straight from its bits: command latch, address latch, chip enable, write enable and card power. A status register shows the device busy line. An interrupt status and mask pair reports each rising edge of the ready line.

A halfword access to the data port becomes two byte cycles on the flash side, with the low byte first. A byte access becomes exactly one cycle. During each cycle the read or write strobe is held low for a fixed number of clocks, set by a parameter. The bus is stalled with a wait signal until the last byte cycle is complete. Register accesses finish without a stall, and their read data appears on the clock edge that accepts them.

Top module: `nand_hw_bridge`

## Requirements
- R1: After reset the mode register reads 0x00. Chip enable is off (nand_ce_n=1), CLE, ALE and the power bits are 0, both strobes are high, irq and bus_wait are 0, and the interrupt status reads 0x00.
- R2: The mode register sits at byte offset 0x4 and reads back what was written. Bit 0 drives nand_cle, bit 1 drives nand_ale, bits 3:2 drive nand_pwr, bit 4 set drives nand_ce_n low, and bit 7 drives nand_wp_n. So 0x94 gives data cycles, 0x95 command cycles, 0x96 address cycles, 0x00 standby with chip enable off, 0x0C supply on and 0x08 supply off.
- R3: A halfword write to the data port (offset 0x0, bus_hw=1) performs two flash write cycles. bus_wdata[7:0] goes out first and bus_wdata[15:8] second.
- R4: A halfword read from the data port performs two flash read cycles. The first byte returned lands in bus_rdata[7:0] and the second in bus_rdata[15:8].
- R5: A byte access (bus_hw=0) to the data port performs exactly one flash cycle. A write sends bus_wdata[7:0]. A read returns the byte in bus_rdata[7:0] with bus_rdata[15:8] at zero.
- R6: In every byte cycle, exactly one strobe is driven low: nand_we_n for writes, nand_re_n for reads. It stays low for STROBE_CLKS consecutive clocks. The two strobes are never low together, and nand_io_out does not change while nand_we_n is low.
- R7: bus_wait is high from the clock after a data-port access is accepted until its last byte cycle ends. Any bus request presented while bus_wait is high is ignored.
- R8: During a flash write cycle, nand_cle and nand_ale keep the values of mode bits 0 and 1 for the whole time nand_we_n is low.
- R9: The status register at offset 0x5 reads 0x80 while the synchronized nand_rdy is low (device busy) and 0x00 while it is high.
- R10: A rising edge of the synchronized nand_rdy sets bit 0 of the interrupt status register at offset 0x6. irq is high when mask bit 7 and mask bit 0 are both set and status bit 0 is set. Writing 0x81 to the mask register at offset 0x7 enables irq and writing 0x00 disables it.
- R11: Writing a 1 to any of bits 3:0 of the interrupt status register clears that bit. Writing 0 leaves the bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, accepted while bus_wait is low |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_hw | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the last completed read |
| bus_wait | output | 1 | Stall while flash byte cycles run |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write permit from mode bit 7 |
| nand_pwr | output | 2 | Card power control |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte returned by the flash |
| nand_rdy | input | 1 | Device ready (1) / busy (0) |
| irq | output | 1 | Ready-request interrupt |

## Verification
The data port is tried with a table of transfers that mixes three things: byte and halfword sizes, reads and writes, and command, address and data modes. For each transfer the bench counts the strobe pulses and their widths. The byte count separates byte from halfword sequencing, and the captured byte order shows whether the halves were swapped. Writes in command and address mode show whether the latch lines were held for the whole strobe. Reads use a flash model that returns a different byte on each strobe, so a repeated or misplaced byte is visible in the returned data. Directed cases then toggle the ready line with the interrupt masked and unmasked, write zeros and then ones to the interrupt status, and present a request in the middle of a transfer.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_HOLD
    } sq_state_e;

    // register offsets on the host bus
    localparam logic [2:0] OFS_DATA = 3'h0;
    localparam logic [2:0] OFS_MODE = 3'h4;
    localparam logic [2:0] OFS_STAT = 3'h5;
    localparam logic [2:0] OFS_ISR  = 3'h6;
    localparam logic [2:0] OFS_IMR  = 3'h7;

    // mode register layout, MSB first
    typedef struct packed {
        logic       wr_permit;
        logic [1:0] ecc_ctl;
        logic       chip_en;
        logic [1:0] power;
        logic       addr_latch;
        logic       cmd_latch;
    } mode_t;

    function automatic logic [7:0] status_byte(input logic busy);
        return {busy, 7'b0};
    endfunction

endpackage

// File: rtl/nbb_regs.sv
module nbb_regs
    import nbb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rd_data,
    input  logic       rdy_in,
    output mode_t      mode,
    output logic       irq
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rdy_s;
    logic                   rdy_prev;
    logic                   rdy_edge;
    logic [3:0]             isr_q;
    logic [3:0]             isr_clr;
    logic [7:0]             imr_q;
    mode_t                  mode_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        logic stage_in;
        if (g == 0) begin : g_first
            assign stage_in = rdy_in;
        end else begin : g_next
            assign stage_in = sync_q[g-1];
        end
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b1;
            else     sync_q[g] <= stage_in;
        end
    end

    assign rdy_s    = sync_q[SYNC_STAGES-1];
    assign rdy_edge = rdy_s & ~rdy_prev;
    assign isr_clr  = (wr_en && addr == OFS_ISR) ? wdata[3:0] : 4'h0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_prev <= 1'b1;
            isr_q    <= 4'h0;
            imr_q    <= 8'h00;
            mode_q   <= '0;
        end else begin
            rdy_prev <= rdy_s;
            isr_q    <= (isr_q & ~isr_clr) | {3'b000, rdy_edge};
            if (wr_en && addr == OFS_IMR)  imr_q  <= wdata;
            if (wr_en && addr == OFS_MODE) mode_q <= mode_t'(wdata);
        end
    end

    always_comb begin
        case (addr)
            OFS_MODE: rd_data = mode_q;
            OFS_STAT: rd_data = status_byte(~rdy_s);
            OFS_ISR:  rd_data = {4'h0, isr_q};
            OFS_IMR:  rd_data = imr_q;
            default:  rd_data = 8'h00;
        endcase
    end

    assign mode = mode_q;
    assign irq  = imr_q[7] & |(isr_q & imr_q[3:0]);

    // R10: a synchronized ready edge is recorded in status bit 0
    p_isr_set_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_s) |=> isr_q[0]);

    // R10: with the global mask bit clear no interrupt leaves the block
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
        !imr_q[7] |-> !irq);

    // R11: write-one-to-clear without a coincident edge empties bit 0
    p_isr_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_ISR && wdata[0] && !$rose(rdy_s)) |=> !isr_q[0]);

endmodule

// File: rtl/nbb_seq.sv
module nbb_seq
    import nbb_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int BUS_W       = 16,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic              full,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BYTE_W-1:0] io_in,
    output logic              busy,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] io_out,
    output logic              io_oe,
    output logic [BUS_W-1:0]  rd_buf
);

    localparam int NBYTES = BUS_W / BYTE_W;
    localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int CW     = $clog2(STROBE_CLKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CLKS - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(NBYTES - 1);

    sq_state_e        state_q;
    logic [IW-1:0]    idx_q;
    logic [IW-1:0]    last_q;
    logic [CW-1:0]    cnt_q;
    logic             wr_q;
    logic [BUS_W-1:0] wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            wd_q    <= '0;
            rd_buf  <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start) begin
                    state_q <= SQ_SETUP;
                    idx_q   <= '0;
                    last_q  <= full ? IDX_LAST : '0;
                    wr_q    <= wr;
                    wd_q    <= wdata;
                    rd_buf  <= '0;
                end
                SQ_SETUP: begin
                    state_q <= SQ_STROBE;
                    cnt_q   <= '0;
                end
                SQ_STROBE: begin
                    if (cnt_q == CNT_LAST) begin
                        state_q <= SQ_HOLD;
                        if (!wr_q) rd_buf[idx_q*BYTE_W +: BYTE_W] <= io_in;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (idx_q != last_q) begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SQ_SETUP;
                    end else begin
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != SQ_IDLE);
    assign we_n   = !(state_q == SQ_STROBE && wr_q);
    assign re_n   = !(state_q == SQ_STROBE && !wr_q);
    assign io_oe  = busy && wr_q;
    assign io_out = wd_q[idx_q*BYTE_W +: BYTE_W];

    // R6: the two strobes are mutually exclusive
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        we_n || re_n);

    // R6: write data holds still while the write strobe is low
    p_io_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> $stable(io_out));

endmodule

// File: rtl/nand_hw_bridge.sv
module nand_hw_bridge
    import nbb_pkg::*;
#(
    parameter int STROBE_CLKS = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic        bus_hw,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        bus_wait,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_ce_n,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic        nand_wp_n,
    output logic [1:0]  nand_pwr,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic [7:0]  nand_io_in,
    input  logic        nand_rdy,
    output logic        irq
);

    logic        seq_busy;
    logic        accept;
    logic        data_acc;
    logic        reg_wr;
    logic        reg_rd;
    logic [7:0]  reg_rdata;
    logic [15:0] seq_rdata;
    logic [15:0] reg_rd_q;
    logic        sel_seq_q;
    mode_t       mode;

    assign accept   = bus_req && !seq_busy;
    assign data_acc = accept && bus_addr == OFS_DATA;
    assign reg_wr   = accept && bus_we && bus_addr != OFS_DATA;
    assign reg_rd   = accept && !bus_we && bus_addr != OFS_DATA;

    nbb_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata[7:0]),
        .rd_data (reg_rdata),
        .rdy_in  (nand_rdy),
        .mode    (mode),
        .irq     (irq)
    );

    nbb_seq #(.STROBE_CLKS(STROBE_CLKS), .BUS_W(16), .BYTE_W(8)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (data_acc),
        .wr     (bus_we),
        .full   (bus_hw),
        .wdata  (bus_wdata),
        .io_in  (nand_io_in),
        .busy   (seq_busy),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .io_out (nand_io_out),
        .io_oe  (nand_io_oe),
        .rd_buf (seq_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rd_q  <= '0;
            sel_seq_q <= 1'b0;
        end else if (data_acc) begin
            sel_seq_q <= 1'b1;
        end else if (reg_rd) begin
            sel_seq_q <= 1'b0;
            reg_rd_q  <= {8'h00, reg_rdata};
        end
    end

    assign bus_rdata = sel_seq_q ? seq_rdata : reg_rd_q;
    assign bus_wait  = seq_busy;
    assign nand_cle  = mode.cmd_latch;
    assign nand_ale  = mode.addr_latch;
    assign nand_ce_n = ~mode.chip_en;
    assign nand_wp_n = mode.wr_permit;
    assign nand_pwr  = mode.power;

    // R7: a strobe is only ever low while the bus is stalled
    p_wait_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> bus_wait);

    // R7, R8: pin state cannot change while a transfer is in flight
    p_pins_hold_r8: assert property (@(posedge clk) disable iff (rst)
        bus_wait |=> $stable({nand_cle, nand_ale, nand_ce_n, nand_pwr}));

endmodule

// File: tb/nand_hw_bridge_tb.sv
module nand_hw_bridge_tb;

    localparam int STROBE = 2;

    typedef struct packed {
        logic [7:0]  mode;
        logic        hw;
        logic        wr;
        logic [15:0] data;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h95, 1'b0, 1'b1, 16'h0070},
        '{8'h96, 1'b1, 1'b1, 16'h3412},
        '{8'h94, 1'b1, 1'b1, 16'hBEEF},
        '{8'h94, 1'b1, 1'b0, 16'h0021},
        '{8'h94, 1'b0, 1'b0, 16'h0080},
        '{8'h94, 1'b0, 1'b1, 16'h55A5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_hw = 1'b0;
    logic [2:0]  bus_addr = 3'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        bus_wait;
    logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_wp_n;
    logic [1:0]  nand_pwr;
    logic [7:0]  nand_io_out;
    logic        nand_io_oe;
    logic [7:0]  nand_io_in;
    logic        nand_rdy = 1'b1;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int we_lo = 0;
    int re_lo = 0;
    int both_lo = 0;
    int wr_n = 0;
    int rd_n = 0;
    int latch_bad = 0;
    logic [7:0] seed = 8'h00;
    logic [7:0] cap [4];
    logic [1:0] cap_lat [4];
    logic [1:0] fall_lat;

    always #2 clk = ~clk;

    nand_hw_bridge #(.STROBE_CLKS(STROBE), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_hw(bus_hw),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_wp_n(nand_wp_n), .nand_pwr(nand_pwr), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rdy(nand_rdy),
        .irq(irq)
    );

    // flash model: a different byte for each read strobe
    assign nand_io_in = seed + 8'(rd_n * 8'h5B);

    always @(posedge clk) begin
        if (!rst) begin
            if (!nand_we_n) we_lo++;
            if (!nand_re_n) re_lo++;
            if (!nand_we_n && !nand_re_n) both_lo++;
        end
    end

    always @(negedge nand_we_n) fall_lat = {nand_ale, nand_cle};

    always @(posedge nand_we_n) begin
        if (!rst && wr_n < 4) begin
            cap[wr_n]     = nand_io_out;
            cap_lat[wr_n] = {nand_ale, nand_cle};
            if (fall_lat != {nand_ale, nand_cle}) latch_bad++;
            wr_n++;
        end
    end

    always @(posedge nand_re_n) if (!rst) rd_n++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic [2:0] a, input logic we, input logic hw,
                            input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_addr = a; bus_we = we; bus_hw = hw; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        while (bus_wait) @(negedge clk);
        rd = bus_rdata;
    endtask

    task automatic clr_mon();
        we_lo = 0; re_lo = 0; wr_n = 0; rd_n = 0; latch_bad = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] exp;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pins", {nand_ce_n, nand_cle, nand_ale, nand_pwr, nand_we_n, nand_re_n, irq, bus_wait},
            {1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0});
        bus_xfer(3'h4, 1'b0, 1'b0, 16'h0, rd);
        chk("R1 mode", rd, 16'h0000);
        bus_xfer(3'h6, 1'b0, 1'b0, 16'h0, rd);
        chk("R1 isr", rd, 16'h0000);

        // R2 power control and standby
        bus_xfer(3'h4, 1'b1, 1'b0, 16'h000C, rd);
        chk("R2 power on", {14'h0, nand_pwr}, 16'h0003);
        bus_xfer(3'h4, 1'b1, 1'b0, 16'h0008, rd);
        chk("R2 power off", {14'h0, nand_pwr}, 16'h0002);
        bus_xfer(3'h4, 1'b1, 1'b0, 16'h0000, rd);
        chk("R2 standby ce_n", {15'h0, nand_ce_n}, 16'h0001);

        // table walk: R2, R3, R4, R5, R6, R8
        foreach (VECS[i]) begin
            vec_t v;
            int nb;
            v  = VECS[i];
            nb = v.hw ? 2 : 1;
            bus_xfer(3'h4, 1'b1, 1'b0, {8'h00, v.mode}, rd);
            bus_xfer(3'h4, 1'b0, 1'b0, 16'h0, rd);
            chk("R2 readback", rd, {8'h00, v.mode});
            chk("R2 pins", {11'h0, nand_wp_n, nand_ce_n, nand_ale, nand_cle, 1'b0},
                {11'h0, v.mode[7], ~v.mode[4], v.mode[1], v.mode[0], 1'b0});
            seed = v.data[7:0];
            clr_mon();
            bus_xfer(3'h0, v.wr, v.hw, v.data, rd);
            if (v.wr) begin
                chk(v.hw ? "R3 byte count" : "R5 byte count", 16'(wr_n), 16'(nb));
                chk("R6 we width", 16'(we_lo), 16'(nb * STROBE));
                chk("R3 first byte", {8'h00, cap[0]}, {8'h00, v.data[7:0]});
                if (v.hw) chk("R3 second byte", {8'h00, cap[1]}, {8'h00, v.data[15:8]});
                chk("R8 latch at strobe", {14'h0, cap_lat[0]}, {14'h0, v.mode[1:0]});
                chk("R8 latch held", 16'(latch_bad), 16'h0);
            end else begin
                exp = v.hw ? {v.data[7:0] + 8'h5B, v.data[7:0]} : {8'h00, v.data[7:0]};
                chk(v.hw ? "R4 read data" : "R5 read data", rd, exp);
                chk("R6 re width", 16'(re_lo), 16'(nb * STROBE));
                chk(v.hw ? "R4 byte count" : "R5 byte count", 16'(rd_n), 16'(nb));
            end
        end
        chk("R6 strobes exclusive", 16'(both_lo), 16'h0);

        // R7: request during a transfer is ignored
        bus_xfer(3'h4, 1'b1, 1'b0, 16'h0094, rd);
        clr_mon();
        @(negedge clk);
        bus_req = 1'b1; bus_addr = 3'h0; bus_we = 1'b1; bus_hw = 1'b1; bus_wdata = 16'hC3D4;
        @(negedge clk);
        chk("R7 wait raised", {15'h0, bus_wait}, 16'h0001);
        bus_addr = 3'h4; bus_wdata = 16'h0000;
        repeat (3) @(negedge clk);
        bus_req = 1'b0;
        while (bus_wait) @(negedge clk);
        bus_xfer(3'h4, 1'b0, 1'b0, 16'h0, rd);
        chk("R7 mode untouched", rd, 16'h0094);
        chk("R7 single transfer", 16'(we_lo), 16'(2 * STROBE));

        // R9 status, R10 interrupt, R11 clear
        bus_xfer(3'h6, 1'b1, 1'b0, 16'h000F, rd);
        bus_xfer(3'h7, 1'b1, 1'b0, 16'h0081, rd);
        nand_rdy = 1'b0;
        repeat (4) @(negedge clk);
        bus_xfer(3'h5, 1'b0, 1'b0, 16'h0, rd);
        chk("R9 busy", rd, 16'h0080);
        chk("R10 no edge no irq", {15'h0, irq}, 16'h0000);
        nand_rdy = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 irq on ready edge", {15'h0, irq}, 16'h0001);
        bus_xfer(3'h5, 1'b0, 1'b0, 16'h0, rd);
        chk("R9 ready", rd, 16'h0000);
        bus_xfer(3'h6, 1'b0, 1'b0, 16'h0, rd);
        chk("R10 isr set", rd, 16'h0001);
        bus_xfer(3'h6, 1'b1, 1'b0, 16'h0000, rd);
        bus_xfer(3'h6, 1'b0, 1'b0, 16'h0, rd);
        chk("R11 zero write keeps", rd, 16'h0001);
        bus_xfer(3'h6, 1'b1, 1'b0, 16'h000F, rd);
        chk("R11 irq cleared", {15'h0, irq}, 16'h0000);
        bus_xfer(3'h6, 1'b0, 1'b0, 16'h0, rd);
        chk("R11 isr cleared", rd, 16'h0000);
        bus_xfer(3'h7, 1'b1, 1'b0, 16'h0000, rd);
        nand_rdy = 1'b0;
        repeat (4) @(negedge clk);
        nand_rdy = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 masked no irq", {15'h0, irq}, 16'h0000);
        bus_xfer(3'h6, 1'b0, 1'b0, 16'h0, rd);
        chk("R10 masked isr set", rd, 16'h0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule